// File: doc/BRIEF.md
# Gamma-projected spinor times link multiplier

This block is a fully pipelined fixed-point datapath for one step of a lattice field kernel. It takes a spinor, a 4-row by 3-column matrix of complex numbers, and a link, a 3×3 complex matrix. It also takes a 3-bit selector that picks one of eight constant gamma projections. The projection is applied to the spinor first. Each projected row is a copy of one input row, scaled by +1, −1, +i or −i. That costs only negations and real/imaginary swaps, with no multipliers. The projected spinor is then multiplied by the link, giving a 4×3 complex result.

A new operation may be presented on every clock. The input side carries a valid/ready pair, and ready is always high because the pipe never stalls. Each accepted operation returns its result a fixed number of clocks later, with a valid flag. Results leave in the order in which operations were accepted. Real and imaginary parts run in parallel lanes.

All numbers are signed two's complement of `DW` bits, with `FRAC` fractional bits. The defaults are 16 and 14, so 1.0 is 16384. Each output element is summed at full precision. It is reduced to the input width only once, at the end.

Top module: `spinor_link_mul`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` stays low until an accepted operation has passed through the pipe, and `in_ready` is high in every cycle.
- R2: An operation is accepted on each rising edge where `in_valid` is high. With defaults, its result appears with `out_valid` high after the 4th rising edge, counting the accepting edge as the first. There is exactly one result per accepted operation, in order. Idle cycles at the input appear as idle cycles at the output.
- R3: Projected row r of gamma select g (`in_gamma`, 0 to 7) is a source row times a factor, listed for r = 0,1,2,3: g0 rows 3,2,1,0 by +i,+i,−i,−i; g1 rows 3,2,1,0 by −1,+1,+1,−1; g2 rows 2,3,0,1 by +i,−i,−i,+i; g3 rows 2,3,0,1 by +1 on all four; g4 rows 0,1,2,3 by +1,+1,−1,−1; g5 rows 1,0,3,2 by −i,−i,+i,+i; g6 rows 1,0,3,2 by +1,−1,−1,+1; g7 rows 0,1,2,3 by +i,−i,+i,−i.
- R4: Multiplying (re, im) by +i gives (−im, re), and by −i gives (im, −re). Every negation saturates, so −(−2^(DW−1)) becomes 2^(DW−1)−1.
- R5: Result element (r, c) is the exact sum over k of P[r][k]·L[k][c], where P is the projected spinor and L the link. The real and imaginary sums are then shifted right arithmetically by `FRAC` bits, which rounds toward minus infinity.
- R6: Each shifted component is saturated to the range −2^(DW−1) to 2^(DW−1)−1.
- R7: Spinor and result element (r, k) sits at index r·3+k, and link element (k, c) at index k·3+c. Element e occupies bits [e·2·DW +: 2·DW] of its bus, with the real part in the low DW bits and the imaginary part in the high DW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the valid pipe |
| in_valid | input | 1 | Operation present on the input buses |
| in_ready | output | 1 | Block accepts an operation (always high) |
| in_gamma | input | 3 | Gamma projection select |
| in_spinor | input | 12·2·DW | Spinor operand, 12 complex elements |
| in_link | input | 9·2·DW | Link operand, 9 complex elements |
| out_valid | output | 1 | Result bus holds a finished operation |
| out_result | output | 12·2·DW | Result, 12 complex elements |

## Verification
The bench sets every spinor element to the most negative code and pushes it through the −1 and ±i rows. If the negation wraps instead of saturating, a huge positive value turns into a huge negative one. Small negative products are checked to come out as −1 rather than 0, which catches a design that rounds toward zero. Operands at full scale drive both the positive and the negative saturation limits, which a missing clamp would wrap. All eight selects are run against an identity link with distinct row values, so a swapped source row or a swapped sign on the ±i rows shows up at once. Random operands are sent both back to back and with gaps, so a pipe that drops, repeats or shifts results by one cycle is caught.

// File: rtl/spmul_pkg.sv
package spmul_pkg;

   localparam int NROW = 4;
   localparam int NCOL = 3;
   localparam int NSPN = NROW * NCOL;
   localparam int NLNK = NCOL * NCOL;

   typedef enum logic [1:0] {
      OP_POS = 2'd0,
      OP_NEG = 2'd1,
      OP_PI  = 2'd2,
      OP_MI  = 2'd3
   } gop_e;

   // Four nibbles, row 0 lowest: {source row[1:0], factor[1:0]}.
   function automatic logic [15:0] gamma_map(input logic [2:0] g);
      case (g)
         3'd0:    return 16'h37AE;
         3'd1:    return 16'h148D;
         3'd2:    return 16'h63FA;
         3'd3:    return 16'h40C8;
         3'd4:    return 16'hD940;
         3'd5:    return 16'hAE37;
         3'd6:    return 16'h8D14;
         default: return 16'hFA72;
      endcase
   endfunction

endpackage

// File: rtl/spmul_gamma.sv
module spmul_gamma
   import spmul_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                  clk,
   input  logic                  load,
   input  logic [2:0]            gsel,
   input  logic [NSPN*2*DW-1:0]  spin,
   output logic [NSPN*2*DW-1:0]  proj
);

   localparam int EW = 2 * DW;

   function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] x);
      if (x == {1'b1, {(DW-1){1'b0}}}) return {1'b0, {(DW-1){1'b1}}};
      return -x;
   endfunction

   logic [15:0]           map;
   logic [NSPN*EW-1:0]    pnext;

   assign map = gamma_map(gsel);

   for (genvar r = 0; r < NROW; r++) begin : g_row
      for (genvar k = 0; k < NCOL; k++) begin : g_col
         int                    si;
         gop_e                  op;
         logic signed [DW-1:0]  xr, xi, yr, yi;

         always_comb begin
            si = int'(map[r*4+2 +: 2]);
            op = gop_e'(map[r*4 +: 2]);
            xr = spin[(si*NCOL+k)*EW +: DW];
            xi = spin[(si*NCOL+k)*EW+DW +: DW];
            case (op)
               OP_POS:  begin yr = xr;          yi = xi;          end
               OP_NEG:  begin yr = neg_sat(xr); yi = neg_sat(xi); end
               OP_PI:   begin yr = neg_sat(xi); yi = xr;          end
               default: begin yr = xi;          yi = neg_sat(xr); end
            endcase
         end

         assign pnext[(r*NCOL+k)*EW +: EW] = {yi, yr};
      end
   end

   always_ff @(posedge clk) begin
      if (load) proj <= pnext;
   end

endmodule

// File: rtl/spmul_cmul.sv
module spmul_cmul #(
   parameter int DW        = 16,
   parameter bit PROD_PIPE = 1'b1
) (
   input  logic                   clk,
   input  logic signed [DW-1:0]   a_re,
   input  logic signed [DW-1:0]   a_im,
   input  logic signed [DW-1:0]   b_re,
   input  logic signed [DW-1:0]   b_im,
   output logic signed [2*DW:0]   p_re,
   output logic signed [2*DW:0]   p_im
);

   localparam int MW = 2 * DW;

   logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;

   always_comb begin
      m_rr = a_re * b_re;
      m_ii = a_im * b_im;
      m_ri = a_re * b_im;
      m_ir = a_im * b_re;
   end

   if (PROD_PIPE) begin : g_two_stage
      logic signed [MW-1:0] q_rr, q_ii, q_ri, q_ir;
      always_ff @(posedge clk) begin
         q_rr <= m_rr;
         q_ii <= m_ii;
         q_ri <= m_ri;
         q_ir <= m_ir;
         p_re <= {q_rr[MW-1], q_rr} - {q_ii[MW-1], q_ii};
         p_im <= {q_ri[MW-1], q_ri} + {q_ir[MW-1], q_ir};
      end
   end else begin : g_one_stage
      always_ff @(posedge clk) begin
         p_re <= {m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii};
         p_im <= {m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir};
      end
   end

endmodule

// File: rtl/spmul_acc.sv
module spmul_acc #(
   parameter int DW    = 16,
   parameter int FRAC  = 14,
   parameter int TERMS = 3
) (
   input  logic                          clk,
   input  logic [TERMS*(2*DW+1)-1:0]     t_re,
   input  logic [TERMS*(2*DW+1)-1:0]     t_im,
   output logic signed [DW-1:0]          o_re,
   output logic signed [DW-1:0]          o_im
);

   localparam int PW = 2 * DW + 1;
   localparam int SW = PW + $clog2(TERMS);

   function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] v);
      logic signed [SW-1:0] hi, lo;
      hi = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
      lo = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};
      if (v > hi) return {1'b0, {(DW-1){1'b1}}};
      if (v < lo) return {1'b1, {(DW-1){1'b0}}};
      return v[DW-1:0];
   endfunction

   logic signed [SW-1:0] s_re, s_im, h_re, h_im;

   always_comb begin
      logic signed [PW-1:0] tr, ti;
      s_re = '0;
      s_im = '0;
      for (int k = 0; k < TERMS; k++) begin
         tr   = t_re[k*PW +: PW];
         ti   = t_im[k*PW +: PW];
         s_re = s_re + SW'(tr);
         s_im = s_im + SW'(ti);
      end
      h_re = s_re >>> FRAC;
      h_im = s_im >>> FRAC;
   end

   always_ff @(posedge clk) begin
      o_re <= clamp(h_re);
      o_im <= clamp(h_im);
   end

endmodule

// File: rtl/spinor_link_mul.sv
module spinor_link_mul
   import spmul_pkg::*;
#(
   parameter int DW        = 16,
   parameter int FRAC      = 14,
   parameter bit PROD_PIPE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [2:0]            in_gamma,
   input  logic [NSPN*2*DW-1:0]  in_spinor,
   input  logic [NLNK*2*DW-1:0]  in_link,
   output logic                  out_valid,
   output logic [NSPN*2*DW-1:0]  out_result
);

   localparam int EW      = 2 * DW;
   localparam int PW      = 2 * DW + 1;
   localparam int LATENCY = 3 + int'(PROD_PIPE);

   if (DW < 4 || DW > 32) begin : g_bad_dw
      $error("spinor_link_mul: DW must lie in 4..32");
   end
   if (FRAC < 0 || FRAC >= DW) begin : g_bad_frac
      $error("spinor_link_mul: FRAC must lie in 0..DW-1");
   end

   logic                  accept;
   logic [LATENCY-1:0]    vpipe;
   logic [NSPN*EW-1:0]    proj;
   logic [NLNK*EW-1:0]    link_q;
   logic [NCOL*PW-1:0]    tre [NSPN];
   logic [NCOL*PW-1:0]    tim [NSPN];

   assign in_ready  = 1'b1;
   assign accept    = in_valid;
   assign out_valid = vpipe[LATENCY-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LATENCY-2:0], accept};
   end

   always_ff @(posedge clk) begin
      if (accept) link_q <= in_link;
   end

   spmul_gamma #(.DW(DW)) gamma_i (
      .clk  (clk),
      .load (accept),
      .gsel (in_gamma),
      .spin (in_spinor),
      .proj (proj)
   );

   for (genvar r = 0; r < NROW; r++) begin : g_r
      for (genvar c = 0; c < NCOL; c++) begin : g_c
         for (genvar k = 0; k < NCOL; k++) begin : g_k
            spmul_cmul #(.DW(DW), .PROD_PIPE(PROD_PIPE)) cmul_i (
               .clk  (clk),
               .a_re (proj[(r*NCOL+k)*EW +: DW]),
               .a_im (proj[(r*NCOL+k)*EW+DW +: DW]),
               .b_re (link_q[(k*NCOL+c)*EW +: DW]),
               .b_im (link_q[(k*NCOL+c)*EW+DW +: DW]),
               .p_re (tre[r*NCOL+c][k*PW +: PW]),
               .p_im (tim[r*NCOL+c][k*PW +: PW])
            );
         end

         spmul_acc #(.DW(DW), .FRAC(FRAC), .TERMS(NCOL)) acc_i (
            .clk  (clk),
            .t_re (tre[r*NCOL+c]),
            .t_im (tim[r*NCOL+c]),
            .o_re (out_result[(r*NCOL+c)*EW +: DW]),
            .o_im (out_result[(r*NCOL+c)*EW+DW +: DW])
         );
      end
   end

endmodule

// File: rtl/spinor_link_mul_chk.sv
module spinor_link_mul_chk #(
   parameter int DW      = 16,
   parameter int LATENCY = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic [12*2*DW-1:0]  in_spinor,
   input logic [9*2*DW-1:0]   in_link,
   input logic                out_valid,
   input logic [12*2*DW-1:0]  out_result
);

   // Edges seen since reset release, saturating at LATENCY.
   int unsigned since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   since_rst <= 0;
      else if (since_rst < LATENCY) since_rst <= since_rst + 1;
   end

   // R2: a result appears exactly LATENCY edges after acceptance
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == LATENCY) |-> (out_valid == $past(in_valid && in_ready, LATENCY)));

   // R7: a finished result carries no unknown bits
   p_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown(out_result));

   // R5: an all-zero link yields an all-zero result
   p_zero_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst == LATENCY) && out_valid && $past(in_link == '0, LATENCY))
      |-> (out_result == '0));

   // R3: no projection turns an all-zero spinor into anything nonzero
   p_zero_spinor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst == LATENCY) && out_valid && $past(in_spinor == '0, LATENCY))
      |-> (out_result == '0));

endmodule

bind spinor_link_mul spinor_link_mul_chk #(.DW(DW), .LATENCY(LATENCY)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_spinor  (in_spinor),
   .in_link    (in_link),
   .out_valid  (out_valid),
   .out_result (out_result)
);

// File: tb/spinor_link_mul_tb_top.sv
module spinor_link_mul_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 16;
   localparam int FRAC = 14;
   localparam int LAT  = 4;
   localparam int NE   = 12;
   localparam int NL   = 9;
   localparam int ONE  = 16384;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [2:0]           in_gamma = '0;
   logic [NE*2*DW-1:0]   in_spinor = '0;
   logic [NL*2*DW-1:0]   in_link = '0;
   logic                 out_valid;
   logic [NE*2*DW-1:0]   out_result;

   always #(CLK_PERIOD/2) clk = ~clk;

   spinor_link_mul #(.DW(DW), .FRAC(FRAC), .PROD_PIPE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_gamma(in_gamma), .in_spinor(in_spinor), .in_link(in_link),
      .out_valid(out_valid), .out_result(out_result)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;

   int sp_re [NE];
   int sp_im [NE];
   int lk_re [NL];
   int lk_im [NL];

   // Projection table from R3; factor codes 0:+1 1:-1 2:+i 3:-i
   int gsrc [8][4] = '{'{3,2,1,0}, '{3,2,1,0}, '{2,3,0,1}, '{2,3,0,1},
                       '{0,1,2,3}, '{1,0,3,2}, '{1,0,3,2}, '{0,1,2,3}};
   int gfac [8][4] = '{'{2,2,3,3}, '{1,0,0,1}, '{2,3,3,2}, '{0,0,0,0},
                       '{0,0,1,1}, '{3,3,2,2}, '{0,1,1,0}, '{2,3,2,3}};

   logic [NE*2*DW-1:0] exp_q [$];
   bit                 vld_q [$];
   string              tag_q [$];

   function automatic int nsat(int x);
      return (x == -32768) ? 32767 : -x;
   endfunction

   function automatic int clamp16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   function automatic logic [NE*2*DW-1:0] model(int g);
      int pr [NE];
      int pi [NE];
      logic [NE*2*DW-1:0] res;
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 3; k++) begin
            int xr, xi, s;
            s  = gsrc[g][r] * 3 + k;
            xr = sp_re[s];
            xi = sp_im[s];
            case (gfac[g][r])
               0: begin pr[r*3+k] = xr;       pi[r*3+k] = xi;       end
               1: begin pr[r*3+k] = nsat(xr); pi[r*3+k] = nsat(xi); end
               2: begin pr[r*3+k] = nsat(xi); pi[r*3+k] = xr;       end
               default: begin pr[r*3+k] = xi; pi[r*3+k] = nsat(xr); end
            endcase
         end
      end
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 3; c++) begin
            longint ar, ai;
            ar = 0;
            ai = 0;
            for (int k = 0; k < 3; k++) begin
               ar += longint'(pr[r*3+k]) * lk_re[k*3+c] - longint'(pi[r*3+k]) * lk_im[k*3+c];
               ai += longint'(pr[r*3+k]) * lk_im[k*3+c] + longint'(pi[r*3+k]) * lk_re[k*3+c];
            end
            res[(r*3+c)*32 +: 16]    = 16'(clamp16(ar >>> FRAC));
            res[(r*3+c)*32+16 +: 16] = 16'(clamp16(ai >>> FRAC));
         end
      end
      return res;
   endfunction

   task automatic compare_outputs();
      bit                 ev;
      logic [NE*2*DW-1:0] er;
      string              et;
      ev = 0;
      er = '0;
      et = "R1";
      if (vld_q.size() >= LAT) begin
         ev = vld_q.pop_front();
         er = exp_q.pop_front();
         et = tag_q.pop_front();
      end
      checks++;
      if (in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1 in_ready actual=%b expected=1", in_ready);
      end
      checks++;
      if (out_valid !== ev) begin
         fails++;
         $display("FAIL %s out_valid actual=%b expected=%b", (vld_q.size() == 0 && !ev) ? "R1" : "R2",
                  out_valid, ev);
      end
      if (ev) begin
         checks++;
         if (out_result !== er) begin
            fails++;
            $display("FAIL %s out_result actual=%h expected=%h", et, out_result, er);
         end
      end
   endtask

   task automatic step(bit v, int g, string tag);
      @(negedge clk);
      compare_outputs();
      in_valid = v;
      in_gamma = 3'(g);
      for (int e = 0; e < NE; e++) begin
         in_spinor[e*32 +: 16]    = 16'(sp_re[e]);
         in_spinor[e*32+16 +: 16] = 16'(sp_im[e]);
      end
      for (int e = 0; e < NL; e++) begin
         in_link[e*32 +: 16]    = 16'(lk_re[e]);
         in_link[e*32+16 +: 16] = 16'(lk_im[e]);
      end
      vld_q.push_back(v);
      exp_q.push_back(v ? model(g) : '0);
      tag_q.push_back(tag);
   endtask

   task automatic link_diag(int d);
      for (int e = 0; e < NL; e++) begin
         lk_re[e] = ((e % 4) == 0) ? d : 0;
         lk_im[e] = 0;
      end
   endtask

   task automatic fill_spinor(int vr, int vi);
      for (int e = 0; e < NE; e++) begin
         sp_re[e] = vr;
         sp_im[e] = vi;
      end
   endtask

   task automatic randomize_ops();
      for (int e = 0; e < NE; e++) begin
         sp_re[e] = int'($urandom_range(0, 65535)) - 32768;
         sp_im[e] = int'($urandom_range(0, 65535)) - 32768;
      end
      for (int e = 0; e < NL; e++) begin
         lk_re[e] = int'($urandom_range(0, 65535)) - 32768;
         lk_im[e] = int'($urandom_range(0, 65535)) - 32768;
      end
   endtask

   initial begin
      fill_spinor(0, 0);
      link_diag(0);
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid in reset actual=%b expected=0", out_valid);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R3, R7: each projection against an identity link, distinct rows
      link_diag(ONE);
      for (int e = 0; e < NE; e++) begin
         sp_re[e] = 100 * (e + 1);
         sp_im[e] = -37 * (e + 1);
      end
      for (int g = 0; g < 8; g++) step(1, g, "R3,R7");

      // R4: most negative code through -1 and +-i rows
      fill_spinor(-32768, -32768);
      step(1, 1, "R4");
      step(1, 0, "R4");
      step(1, 5, "R4");
      fill_spinor(-32768, 5);
      step(1, 7, "R4");

      // R5: floor rounding of small negative values
      fill_spinor(-1, 3);
      link_diag(1);
      step(1, 3, "R5");
      link_diag(16383);
      step(1, 3, "R5");

      // R6: saturation at both limits
      fill_spinor(32767, 32767);
      for (int e = 0; e < NL; e++) begin
         lk_re[e] = 32767;
         lk_im[e] = 32767;
      end
      step(1, 3, "R6");
      step(1, 1, "R6");
      step(1, 2, "R6");

      // R5: random operands back to back over all selects
      for (int i = 0; i < 160; i++) begin
         randomize_ops();
         step(1, i % 8, "R5");
      end

      // R2: random operands with gaps at the input
      for (int i = 0; i < 160; i++) begin
         randomize_ops();
         step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "R2");
      end

      for (int i = 0; i < LAT + 2; i++) step(0, 0, "R2");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule